// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave side of a SPI link that fronts a 64K x 8 non-volatile array. It brings chip select, serial clock and data in onto the system clock, collects a one-byte command, an optional big-endian address and data bytes, and turns them into array reads, byte or page write bursts, and access to a small status register. Read data leaves on `miso_o`, and `miso_oe_o` enables the pad's tri-state driver.

Writes are held in a one-page buffer and are committed only when chip select rises after a whole number of bytes. A commit starts a programmable busy window that stands in for the cell program time. During that window the buffered bytes are drained to the array port, and only the status command is accepted. An external permission unit looks at the page being written and at the stored configuration bits, and it approves or vetoes each array write.

Top module: `spi_mem_front`

## Requirements
- R1: Input bits are taken on rising SCK edges and output bits change after falling SCK edges, whether SCK idles low (mode 0) or high (mode 3).
- R2: Command codes are 0x06 set write latch, 0x04 clear write latch, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write. Array commands carry a 16-bit address, high byte first, each byte MSB first.
- R3: Any other command code makes the block ignore SCK and MOSI and keep `miso_oe_o` low until chip select has gone high and low again.
- R4: A status write or array write takes effect only if the SCK rising-edge count at deselect is a multiple of 8. It also needs at least one data byte. Otherwise nothing changes: the write latch, the status bits and the array all keep their values, and busy stays low.
- R5: The write latch is set by 0x06. It is cleared by 0x04 and by every accepted write. Writes sent while it is clear are ignored.
- R6: The status byte reads as bit 0 busy, bit 1 write latch, and bits 7..2 stored configuration. A status write loads data bits 7..2 into the configuration field and drives the same field on `sr_cfg_o`.
- R7: An accepted write holds `busy_o` high for exactly TWR_CYCLES clocks. Status reads work during that window, and every other command is rejected.
- R8: An array read returns the byte at the address and then successive bytes for as long as SCK runs. The address wraps from 0xFFFF to 0x0000.
- R9: Write data fills a PAGE_BYTES-aligned page. The offset wraps within that page, and when an offset is written twice the later byte wins.
- R10: `wr_page_o` gives the page number of the current write. An array write whose `wr_ok_i` is low at deselect is dropped, and the write latch keeps its value.
- R11: `miso_oe_o` is high only while read or status data is being shifted out, and only while the block is selected.
- R12: After reset the status reads 0x00, `miso_oe_o` and `busy_o` are low, and no array write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SPI pins are oversampled on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| mem_raddr_o | output | AW | Array read address |
| mem_rdata_i | input | 8 | Array read data for `mem_raddr_o` |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_waddr_o | output | AW | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| wr_page_o | output | AW-PW | Page of the current write, sent to the permission unit |
| wr_ok_i | input | 1 | Permission unit approval of the array write |
| sr_cfg_o | output | 6 | Stored status configuration bits 7..2 |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The bench builds the block with a 16-byte page and a 400-clock write window and keeps the 16-bit address. The small page puts in-page wrap and same-offset overwrites within reach of short bursts. The short window lets status reads land inside a running write cycle and lets a rejected command arrive while busy, and both still fit in a compact run. Because the address stays at full width, the read can also cross from 0xFFFF to 0x0000.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_SKIP} fe_state_e;

  function automatic logic is_op(input logic [7:0] c);
    return (c >= OP_WRSR) && (c <= OP_WREN);
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/spi_fe_busy.sv
module spi_fe_busy #(
  parameter int TWR_CYCLES = 5000,
  localparam int CW = $clog2(TWR_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(TWR_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  a_r7_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/spi_fe_pagebuf.sv
module spi_fe_pagebuf #(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 128,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [PW-1:0]    off_i,
  input  logic [7:0]       data_i,
  input  logic             go_i,
  input  logic [AW-PW-1:0] page_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic             active_o
);
  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PW-1:0]         idx_q;
  logic [AW-PW-1:0]      page_q;
  logic                  run_q, we_q;
  logic [AW-1:0]         waddr_q;
  logic [7:0]            wdata_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) buf_q[off_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      idx_q   <= '0;
      page_q  <= '0;
      run_q   <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (clr_i) vld_q <= '0;
      if (wr_i)  vld_q[off_i] <= 1'b1;
      if (go_i) begin
        run_q  <= 1'b1;
        idx_q  <= '0;
        page_q <= page_i;
      end else if (run_q) begin
        we_q         <= vld_q[idx_q];
        waddr_q      <= {page_q, idx_q};
        wdata_q      <= buf_q[idx_q];
        vld_q[idx_q] <= 1'b0;
        idx_q        <= idx_q + PW'(1);
        if (idx_q == PW'(PAGE_BYTES - 1)) run_q <= 1'b0;
      end
    end
  end

  assign we_o     = we_q;
  assign waddr_o  = waddr_q;
  assign wdata_o  = wdata_q;
  assign active_o = run_q | we_q;

  // a burst never leaves the page it started in
  a_r9_one_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && $past(we_q)) |-> $stable(waddr_q[AW-1:PW]));
  a_r4_drain_after_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(run_q));
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_fe_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 128,
  parameter int TWR_CYCLES = 5000,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic [AW-1:0]    mem_raddr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_waddr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [AW-PW-1:0] wr_page_o,
  input  logic             wr_ok_i,
  output logic [5:0]       sr_cfg_o,
  output logic             busy_o
);
  localparam int ADDR_BYTES = AW / 8;

  logic [2:0] pin_q;
  logic       cs_q, sck_q, mosi_q, cs_d, sck_d;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;

  spi_fe_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, sck_i, cs_ni}),
    .q_o   (pin_q)
  );

  assign cs_q   = pin_q[0];
  assign sck_q  = pin_q[1];
  assign mosi_q = pin_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_q;
      sck_d <= sck_q;
    end
  end

  assign cs_rise  = cs_q & ~cs_d;
  assign cs_fall  = ~cs_q & cs_d;
  assign sck_rise = sck_q & ~sck_d;
  assign sck_fall = ~sck_q & sck_d;

  fe_state_e     st_q;
  logic [7:0]    op_q, nby_q, tx_q, byte_w, load_w;
  logic [6:0]    rx_q;
  logic [2:0]    bit_q;
  logic [AW-1:0] addr_q;
  logic [5:0]    sr_new_q, sr_q;
  logic          wel_q, oe_q, byte_done, is_arr, out_phase, at_end;
  logic          do_wren, do_wrdi, do_wrsr, do_write;
  logic          buf_clr, buf_wr, cyc_busy, buf_active;

  assign byte_w    = {rx_q, mosi_q};
  assign byte_done = (st_q == ST_CMD) && !cs_q && sck_rise && (bit_q == 3'd7);
  assign is_arr    = (op_q == OP_READ) || (op_q == OP_WRITE);
  assign out_phase = ((op_q == OP_READ) && (nby_q >= 8'(ADDR_BYTES + 1))) ||
                     ((op_q == OP_RDSR) && (nby_q >= 8'd1));
  assign load_w    = (op_q == OP_READ) ? mem_rdata_i : {sr_q, wel_q, busy_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      nby_q    <= '0;
      addr_q   <= '0;
      sr_new_q <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
    end else if (cs_q) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (cs_fall) begin
      st_q  <= ST_CMD;
      bit_q <= '0;
      nby_q <= '0;
      oe_q  <= 1'b0;
    end else if (st_q == ST_CMD) begin
      if (sck_rise) begin
        rx_q  <= {rx_q[5:0], mosi_q};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (nby_q != 8'hFF) nby_q <= nby_q + 8'd1;
          if (nby_q == 8'd0) begin
            op_q <= byte_w;
            if (!is_op(byte_w) || (busy_o && byte_w != OP_RDSR)) st_q <= ST_SKIP;
          end else if (is_arr && nby_q <= 8'(ADDR_BYTES)) begin
            addr_q <= {addr_q[AW-9:0], byte_w};
          end else if (op_q == OP_WRITE) begin
            addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
          end
          if (op_q == OP_WRSR && nby_q == 8'd1) sr_new_q <= byte_w[7:2];
        end
      end else if (sck_fall && out_phase) begin
        if (bit_q == 3'd0) begin
          tx_q <= load_w;
          oe_q <= 1'b1;
          if (op_q == OP_READ) addr_q <= addr_q + AW'(1);
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // commit decisions at deselect; only whole bytes count
  assign at_end   = cs_rise && (st_q == ST_CMD) && (bit_q == 3'd0);
  assign do_wren  = at_end && (op_q == OP_WREN) && (nby_q >= 8'd1);
  assign do_wrdi  = at_end && (op_q == OP_WRDI) && (nby_q >= 8'd1);
  assign do_wrsr  = at_end && (op_q == OP_WRSR) && (nby_q >= 8'd2) && wel_q;
  assign do_write = at_end && (op_q == OP_WRITE) && (nby_q >= 8'(ADDR_BYTES + 2))
                    && wel_q && wr_ok_i;

  assign buf_clr = byte_done && (nby_q == 8'd0) && (byte_w == OP_WRITE) && !busy_o;
  assign buf_wr  = byte_done && (op_q == OP_WRITE) && (nby_q > 8'(ADDR_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      sr_q  <= '0;
    end else begin
      if (do_wren) wel_q <= 1'b1;
      else if (do_wrdi || do_wrsr || do_write) wel_q <= 1'b0;
      if (do_wrsr) sr_q <= sr_new_q;
    end
  end

  spi_fe_busy #(.TWR_CYCLES(TWR_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(do_wrsr | do_write),
    .busy_o (cyc_busy)
  );

  spi_fe_pagebuf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .wr_i    (buf_wr),
    .off_i   (addr_q[PW-1:0]),
    .data_i  (byte_w),
    .go_i    (do_write),
    .page_i  (addr_q[AW-1:PW]),
    .we_o    (mem_we_o),
    .waddr_o (mem_waddr_o),
    .wdata_o (mem_wdata_o),
    .active_o(buf_active)
  );

  assign busy_o      = cyc_busy | buf_active;
  assign miso_oe_o   = oe_q;
  assign miso_o      = oe_q ? tx_q[7] : 1'b0;
  assign mem_raddr_o = addr_q;
  assign wr_page_o   = addr_q[AW-1:PW];
  assign sr_cfg_o    = sr_q;

  a_r11_oe_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !miso_oe_o);
  a_r3_skip_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !miso_oe_o);
  a_r5_latch_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !wel_q);
  a_r4_commit_at_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_q));
  a_r7_write_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  a_r6_cfg_needs_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sr_q) |-> $past(wel_q));
endmodule

// File: tb/tb_spi_mem_front.sv
module tb_spi_mem_front;
  localparam int AW = 16;
  localparam int PAGE = 16;
  localparam int TWR = 400;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wr_ok = 1'b1, cpol = 1'b0;
  logic miso, miso_oe, mem_we, busy;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rdata = 8'h00, mem_wdata;
  logic [11:0] wr_page;
  logic [5:0] sr_cfg;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [int];
  logic [7:0] expm [int];
  logic [7:0] wbuf [64];
  int run_len = 0, last_len = 0;

  always #10 clk = ~clk;

  spi_mem_front #(.AW(AW), .PAGE_BYTES(PAGE), .TWR_CYCLES(TWR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .wr_page_o(wr_page), .wr_ok_i(wr_ok), .sr_cfg_o(sr_cfg), .busy_o(busy)
  );

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_waddr)] = mem_wdata;
    mem_rdata <= mem.exists(int'(mem_raddr)) ? mem[int'(mem_raddr)] : 8'h00;
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return expm.exists(int'(a)) ? expm[int'(a)] : 8'h00;
  endfunction

  task automatic model_write(input logic [15:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] wa;
      wa = {a[15:4], 4'(a[3:0] + 4'(k))};
      expm[int'(wa)] = wbuf[k];
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = cpol; tick(H); cs_n = 1'b0; tick(H);
  endtask

  task automatic desel();
    tick(H); cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic bitx(input logic b, output logic r, output logic o);
    if (cpol) begin
      sck = 1'b0; mosi = b; tick(H);
      r = miso; o = miso_oe; sck = 1'b1; tick(H);
    end else begin
      mosi = b; tick(H);
      r = miso; o = miso_oe; sck = 1'b1; tick(H); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic r, o;
      bitx(tx[i], r, o);
      rx[i] = r; oe_all &= o; oe_any |= o;
    end
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [7:0] r; logic a, y;
    sel(); xfer(c, r, a, y); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r; logic a, y;
    sel(); xfer(8'h05, r, a, y); xfer(8'h00, s, a, y); desel();
  endtask

  task automatic wrsr(input logic [7:0] v, input int extra);
    logic [7:0] r; logic a, y, rb, o;
    sel(); xfer(8'h01, r, a, y); xfer(v, r, a, y);
    for (int k = 0; k < extra; k++) bitx(1'b1, rb, o);
    desel();
  endtask

  task automatic spi_write(input logic [15:0] ad, input int n, input int extra);
    logic [7:0] r; logic a, y, rb, o;
    sel(); xfer(8'h02, r, a, y); xfer(ad[15:8], r, a, y); xfer(ad[7:0], r, a, y);
    for (int k = 0; k < n; k++) xfer(wbuf[k], r, a, y);
    for (int k = 0; k < extra; k++) bitx(1'b1, rb, o);
    desel();
  endtask

  task automatic read_cmp(input logic [15:0] ad, input int n, input string tag);
    logic [7:0] r; logic a, y;
    logic any_cmd;
    sel();
    xfer(8'h03, r, a, y); any_cmd = y;
    xfer(ad[15:8], r, a, y); any_cmd |= y;
    xfer(ad[7:0], r, a, y); any_cmd |= y;
    chk({tag, " R11 oe during command"}, any_cmd, 1'b0);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r, a, y);
      chk({tag, " R8 data"}, r, exp_rd(ad + 16'(i)));
      chk({tag, " R11 oe during data"}, a, 1'b1);
    end
    desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    int g = 0;
    do begin rdsr(s); g++; end while (s[0] && g < 50);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    logic a, y;
    void'($urandom(32'd2024));
    tick(5);
    chk("R12 oe at reset", miso_oe, 1'b0);
    chk("R12 busy at reset", busy, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R12 no write at reset", mem_we, 1'b0);
    rdsr(s); chk("R12 status after reset", s, 8'h00);

    // R5 latch set/clear
    cmd1(8'h06); rdsr(s); chk("R5 R6 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R5 latch cleared", s, 8'h00);

    // R5 write without latch
    wbuf[0] = 8'hAA;
    spi_write(16'h1234, 1, 0);
    chk("R5 no busy without latch", busy, 1'b0);
    read_cmp(16'h1234, 1, "R5 ignored write");

    // R7 busy window, mode 0 write, mode 3 readback
    cmd1(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    spi_write(16'h1234, 3, 0); model_write(16'h1234, 3);
    rdsr(s); chk("R7 R6 status while busy", s, 8'h01);
    cmd1(8'h06);
    wait_ready();
    rdsr(s); chk("R7 latch command rejected while busy", s, 8'h00);
    chk("R7 busy length", last_len, TWR);
    cpol = 1'b1;
    read_cmp(16'h1234, 3, "R1 R2 mode3 readback");
    cpol = 1'b0;

    // R4 partial byte and no-data writes dropped
    cmd1(8'h06);
    wbuf[0] = 8'h55;
    spi_write(16'h1240, 1, 3);
    chk("R4 no busy after partial", busy, 1'b0);
    rdsr(s); chk("R4 latch kept after partial", s, 8'h02);
    spi_write(16'h1241, 0, 0);
    rdsr(s); chk("R4 latch kept without data", s, 8'h02);
    read_cmp(16'h1240, 2, "R4 array unchanged");

    // R3 unknown opcode then a clear-latch pattern
    sel(); xfer(8'hAB, r, a, y); xfer(8'h04, r, a, s[0]); desel();
    chk("R3 oe stays low", s[0], 1'b0);
    rdsr(s); chk("R3 bus ignored", s, 8'h02);

    // R9 page wrap
    for (int k = 0; k < 5; k++) wbuf[k] = 8'hA0 + 8'(k);
    spi_write(16'h205E, 5, 0); model_write(16'h205E, 5);
    wait_ready();
    read_cmp(16'h2050, 16, "R9 wrap");
    cmd1(8'h06);
    for (int k = 0; k < 18; k++) wbuf[k] = 8'hB0 + 8'(k);
    spi_write(16'h2050, 18, 0); model_write(16'h2050, 18);
    wait_ready();
    read_cmp(16'h2050, 16, "R9 later wins");

    // R8 address wrap
    cmd1(8'h06); wbuf[0] = 8'h5A; spi_write(16'hFFFF, 1, 0); model_write(16'hFFFF, 1); wait_ready();
    cmd1(8'h06); wbuf[0] = 8'hA5; spi_write(16'h0000, 1, 0); model_write(16'h0000, 1); wait_ready();
    read_cmp(16'hFFFF, 2, "R8 wrap");

    // R10 permission veto
    wr_ok = 1'b0;
    cmd1(8'h06);
    sel(); xfer(8'h02, r, a, y); xfer(8'h34, r, a, y); xfer(8'h56, r, a, y);
    chk("R10 page out", wr_page, 12'h345);
    xfer(8'h77, r, a, y); desel();
    chk("R10 no busy on veto", busy, 1'b0);
    rdsr(s); chk("R10 latch kept", s, 8'h02);
    read_cmp(16'h3456, 1, "R10 array unchanged");
    wr_ok = 1'b1;

    // R6 status write
    wrsr(8'hFC, 0); wait_ready();
    rdsr(s); chk("R6 status written", s, 8'hFC);
    chk("R6 cfg out", sr_cfg, 6'h3F);
    cmd1(8'h06); wrsr(8'h00, 4);
    rdsr(s); chk("R4 R6 partial status write dropped", s, 8'hFE);
    cmd1(8'h04); rdsr(s); chk("R5 clear latch", s, 8'hFC);
    cmd1(8'h06); wrsr(8'h00, 0); wait_ready();
    rdsr(s); chk("R6 status restored", s, 8'h00);

    // constrained random writes and readback
    for (int it = 0; it < 12; it++) begin
      logic [15:0] ad;
      int n;
      logic en;
      cpol = 1'($urandom % 2);
      ad = 16'($urandom);
      n = 1 + int'($urandom % 20);
      en = ($urandom % 4) != 0;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      cmd1(en ? 8'h06 : 8'h04);
      spi_write(ad, n, 0);
      if (en) model_write(ad, n);
      chk("R5 R7 busy follows latch", busy, en);
      wait_ready();
      read_cmp({ad[15:4], 4'h0}, PAGE, "R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule